// File: doc/BRIEF.md
# USB Line-State Diagnostic Forcer

This block holds one 16-bit diagnostic control word that can override the D+/D– data lines of two USB ports with fixed test conditions during device characterization. A 3-bit force code chooses the condition: single-ended zero, a continuous J/K alternation paced by a bit-time strobe, a static J, or a static K. Each port applies that condition only while its own diagnostic enable bit is set. The same word also carries three pull-resistor enables: a full-speed pull-down on both lines, a low-speed pull-up on D–, and a full-speed pull-up on D+. These drive their outputs directly and do not depend on the port enables.

Two agents write the word. The local CPU bus writes it and reads it back. The host-processor port can only write it. When both write in the same cycle, the CPU value is stored. Bits with no function are never stored, so they always read back as 0. Line polarity is full-speed: J is D+ high with D– low, and K is the reverse.

Top module: `usb_line_diag`

## Requirements
- R1: After reset the stored word reads 0, every force_en and line output is 0, and all three pull enables are 0.
- R2: A CPU write stores cpu_wdata ANDed with the writable mask 0xA077, and cpu_rdata shows it from the next cycle. Reserved bits always read back as 0.
- R3: A host write with no CPU write in the same cycle stores host_wdata ANDed with 0xA077. The value becomes visible on cpu_rdata on the next cycle.
- R4: When cpu_wr_en and host_wr_en are both high in one cycle, the CPU data is stored and the host data is discarded.
- R5: force_en[0] equals bit 13 and force_en[1] equals bit 15. When a port's force_en is 0, its dp_out and dm_out are 0.
- R6: When a port is enabled and bit 2 is 1, the port drives SE0: dp_out=0 and dm_out=0.
- R7: When a port is enabled and bits [2:0]=001, it drives J (dp_out=1, dm_out=0). When a port is enabled and bits [2:0]=000, it drives K (dp_out=0, dm_out=1).
- R8: Bits [2:0]=01x select toggle mode. The pattern is J in the first cycle after the mode is entered, and it swaps J/K on the cycle after each cycle in which bit_tick is high.
- R9: Bit 6 drives pd_en, bit 5 drives ls_pu_en and bit 4 drives fs_pu_en, whatever the port enables hold.
- R10: Leaving toggle mode and entering it again restarts the pattern at J. Writing toggle mode again while already in toggle mode keeps the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data (stored word) |
| host_wr_en | input | 1 | Host-port write strobe |
| host_wdata | input | 16 | Host-port write data |
| bit_tick | input | 1 | One-bit-time strobe that paces toggle mode |
| force_en | output | 2 | Per-port line override enable |
| dp_out | output | 2 | Per-port forced D+ level |
| dm_out | output | 2 | Per-port forced D– level |
| pd_en | output | 1 | Pull-down enable on D+ and D– |
| ls_pu_en | output | 1 | Low-speed pull-up enable on D– |
| fs_pu_en | output | 1 | Full-speed pull-up enable on D+ |

## Verification
A corrupted stored bit shows up on cpu_rdata and on the matching line or pull output in the same cycle, so a stuck or misdecoded bit is caught on the next compare. A wrong toggle phase is the one internal fault that the read path cannot show. It is visible only on dp_out and dm_out, and only while a port is enabled in toggle mode. For that reason the bench holds toggle mode across many ticks and then leaves and re-enters it, so a wrong phase is exposed within one cycle of a tick or of re-entry.

// File: rtl/usb_diag_pkg.sv
package usb_diag_pkg;
  localparam int REG_W      = 16;
  localparam int NUM_PORTS  = 2;
  localparam int FORCE_W    = 3;
  localparam int EN0_BIT    = 13;
  localparam int EN1_BIT    = 15;
  localparam int PD_BIT     = 6;
  localparam int LSPU_BIT   = 5;
  localparam int FSPU_BIT   = 4;
  localparam logic [REG_W-1:0] WR_MASK = 16'hA077;

  typedef enum logic [1:0] {
    DRV_K      = 2'd0,
    DRV_J      = 2'd1,
    DRV_TOGGLE = 2'd2,
    DRV_SE0    = 2'd3
  } drv_mode_e;

  function automatic drv_mode_e decode_force(input logic [FORCE_W-1:0] code);
    if (code[2])      return DRV_SE0;
    else if (code[1]) return DRV_TOGGLE;
    else if (code[0]) return DRV_J;
    else              return DRV_K;
  endfunction

  function automatic int port_en_bit(input int p);
    return (p == 0) ? EN0_BIT : EN1_BIT;
  endfunction
endpackage

// File: rtl/diag_rst_sync.sv
module diag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[STAGES-1];
endmodule

// File: rtl/diag_ctrl_reg.sv
module diag_ctrl_reg #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_wr_en,
  input  logic [W-1:0] cpu_wdata,
  input  logic         host_wr_en,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] word_q
);
  logic         load_en;
  logic [W-1:0] word_d;

  always_comb begin
    load_en = cpu_wr_en | host_wr_en;
    if (cpu_wr_en) word_d = cpu_wdata & MASK;
    else           word_d = host_wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (load_en) word_q <= word_d;
  end
endmodule

// File: rtl/diag_pattern_gen.sv
module diag_pattern_gen
  import usb_diag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FORCE_W-1:0] force_code,
  input  logic               bit_tick,
  output logic               pat_dp,
  output logic               pat_dm
);
  drv_mode_e mode;
  logic      phase_q;
  logic      phase_d;
  logic      phase_en;

  always_comb begin
    mode = decode_force(force_code);
  end

  // phase 0 = J, 1 = K; held at J outside toggle mode
  always_comb begin
    phase_en = 1'b0;
    phase_d  = phase_q;
    if (mode != DRV_TOGGLE) begin
      phase_en = phase_q;
      phase_d  = 1'b0;
    end else if (bit_tick) begin
      phase_en = 1'b1;
      phase_d  = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (phase_en) phase_q <= phase_d;
  end

  always_comb begin
    unique case (mode)
      DRV_SE0:    begin pat_dp = 1'b0;     pat_dm = 1'b0;    end
      DRV_TOGGLE: begin pat_dp = ~phase_q; pat_dm = phase_q; end
      DRV_J:      begin pat_dp = 1'b1;     pat_dm = 1'b0;    end
      default:    begin pat_dp = 1'b0;     pat_dm = 1'b1;    end
    endcase
  end
endmodule

// File: rtl/diag_port_gate.sv
module diag_port_gate (
  input  logic port_en,
  input  logic pat_dp,
  input  logic pat_dm,
  output logic ovr_en,
  output logic ovr_dp,
  output logic ovr_dm
);
  always_comb begin
    ovr_en = port_en;
    ovr_dp = port_en & pat_dp;
    ovr_dm = port_en & pat_dm;
  end
endmodule

// File: rtl/usb_line_diag.sv
module usb_line_diag
  import usb_diag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_wr_en,
  input  logic [REG_W-1:0]     cpu_wdata,
  output logic [REG_W-1:0]     cpu_rdata,
  input  logic                 host_wr_en,
  input  logic [REG_W-1:0]     host_wdata,
  input  logic                 bit_tick,
  output logic [NUM_PORTS-1:0] force_en,
  output logic [NUM_PORTS-1:0] dp_out,
  output logic [NUM_PORTS-1:0] dm_out,
  output logic                 pd_en,
  output logic                 ls_pu_en,
  output logic                 fs_pu_en
);
  logic             rst_n_int;
  logic [REG_W-1:0] word_q;
  logic             pat_dp;
  logic             pat_dm;

  diag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  diag_ctrl_reg #(.W(REG_W), .MASK(WR_MASK)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cpu_wr_en  (cpu_wr_en),
    .cpu_wdata  (cpu_wdata),
    .host_wr_en (host_wr_en),
    .host_wdata (host_wdata),
    .word_q     (word_q)
  );

  diag_pattern_gen u_pat (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .force_code (word_q[FORCE_W-1:0]),
    .bit_tick   (bit_tick),
    .pat_dp     (pat_dp),
    .pat_dm     (pat_dm)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    diag_port_gate u_gate (
      .port_en (word_q[port_en_bit(p)]),
      .pat_dp  (pat_dp),
      .pat_dm  (pat_dm),
      .ovr_en  (force_en[p]),
      .ovr_dp  (dp_out[p]),
      .ovr_dm  (dm_out[p])
    );
  end

  assign cpu_rdata = word_q;
  assign pd_en     = word_q[PD_BIT];
  assign ls_pu_en  = word_q[LSPU_BIT];
  assign fs_pu_en  = word_q[FSPU_BIT];
endmodule

// File: rtl/usb_line_diag_chk.sv
module usb_line_diag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr_en,
  input logic [15:0] cpu_wdata,
  input logic [15:0] cpu_rdata,
  input logic        host_wr_en,
  input logic [15:0] host_wdata,
  input logic        bit_tick,
  input logic [1:0]  force_en,
  input logic [1:0]  dp_out,
  input logic [1:0]  dm_out
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata & 16'h5F88) == 16'h0000);

  // R4
  cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && $past(rst_n)) |=> cpu_rdata == ($past(cpu_wdata) & 16'hA077));

  // R3
  host_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && !cpu_wr_en && $past(rst_n)) |=> cpu_rdata == ($past(host_wdata) & 16'hA077));

  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !force_en[0] |-> (!dp_out[0] && !dm_out[0]));

  // R6
  se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en[1] && cpu_rdata[2]) |-> (!dp_out[1] && !dm_out[1]));

  // R8
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en[0] && cpu_rdata[2:1] == 2'b01 && bit_tick && !cpu_wr_en && !host_wr_en)
      |=> dp_out[0] != $past(dp_out[0]));
endmodule

bind usb_line_diag usb_line_diag_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_wr_en  (cpu_wr_en),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .host_wr_en (host_wr_en),
  .host_wdata (host_wdata),
  .bit_tick   (bit_tick),
  .force_en   (force_en),
  .dp_out     (dp_out),
  .dm_out     (dm_out)
);

// File: tb/sim_usb_line_diag.sv
`timescale 1ns/1ps
module sim_usb_line_diag;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        host_wr_en = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        bit_tick = 1'b0;
  logic [1:0]  force_en, dp_out, dm_out;
  logic        pd_en, ls_pu_en, fs_pu_en;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  int m_word = 0;
  int m_phase = 0;

  always #5 clk = ~clk;

  usb_line_diag u0 (.*);

  // reference model: behavioural update at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_word = 0;
      m_phase = 0;
    end else begin
      if (((m_word & 7) >> 1) == 1) begin
        if (bit_tick) m_phase = 1 - m_phase;
      end else m_phase = 0;
      if (cpu_wr_en)       m_word = int'(cpu_wdata) & 'hA077;
      else if (host_wr_en) m_word = int'(host_wdata) & 'hA077;
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int code, en, edp, edm;
    code = m_word & 7;
    cmp({tag, " R2"}, "cpu_rdata", int'(cpu_rdata), m_word);
    cmp({tag, " R9"}, "pulls", int'({pd_en, ls_pu_en, fs_pu_en}), (m_word >> 4) & 7);
    for (int p = 0; p < 2; p++) begin
      en = (m_word >> (p == 0 ? 13 : 15)) & 1;
      if (code >= 4)      begin edp = 0; edm = 0; end
      else if (code >= 2) begin edp = 1 - m_phase; edm = m_phase; end
      else if (code == 1) begin edp = 1; edm = 0; end
      else                begin edp = 0; edm = 1; end
      cmp({tag, " R5"}, "force_en", int'(force_en[p]), en);
      cmp({tag, " R6/R7/R8"}, "dp_out", int'(dp_out[p]), en & edp);
      cmp({tag, " R6/R7/R8"}, "dm_out", int'(dm_out[p]), en & edm);
    end
  endtask

  task automatic step(input string tag, input logic cw, input logic [15:0] cd,
                      input logic hw, input logic [15:0] hd, input logic tk);
    @(negedge clk);
    check_all(tag);
    cpu_wr_en = cw; cpu_wdata = cd;
    host_wr_en = hw; host_wdata = hd; bit_tick = tk;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_all("R1");
    rst_n = 1'b1;
    repeat (4) step("R1", 0, 0, 0, 0, 0);
    // R2: CPU write with reserved bits set
    step("R2", 1, 16'hFFFF, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    // R3: host write
    step("R3", 0, 0, 1, 16'h2051, 0);
    step("R3", 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0);
    // R4: simultaneous writes
    step("R4", 1, 16'h8011, 1, 16'h2060, 0);
    step("R4", 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0);
    // R7: static J and K on both ports
    step("R7", 1, 16'hA001, 0, 0, 0);
    step("R7", 1, 16'hA000, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0);
    // R6: SE0 with port 1 only, pulls ungated (R9)
    step("R6", 1, 16'h8074, 0, 0, 0);
    step("R9", 1, 16'h0070, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0);
    // R8: toggle with ticks
    step("R8", 1, 16'hA002, 0, 0, 0);
    for (int i = 0; i < 20; i++) step("R8", 0, 0, 0, 0, logic'(i % 3 != 1));
    // R10: rewrite toggle keeps phase, leave and re-enter restarts at J
    step("R10", 0, 0, 0, 0, 1);
    step("R10", 1, 16'hA003, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0);
    step("R10", 1, 16'hA001, 0, 0, 1);
    step("R10", 1, 16'hA002, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 1);
    step("R10", 0, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("MIX", logic'(r[0] & r[1] & r[2]), r[31:16],
           logic'(r[3] & r[4] & r[5]), r[15:0] ^ 16'h5A5A, r[6]);
    end
    step("END", 0, 0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule